// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a self-timed bus of `W` logical bits. Each bit travels on a pair of wires: a "one" rail and a "zero" rail. A pair with neither rail high is the spacer, which means no data. A pair with exactly one rail high carries a value. For every pair, the block ORs the two rails into a per-bit "present" signal. A balanced tree of two-input Muller C-elements then merges the present signals into one `done_o` output.

Each C-element holds its state. Its output moves only when both of its inputs agree. As a result, `done_o` rises only after every bit carries data and falls only after every bit has gone back to the spacer. It therefore marks both edges of a four-phase data/spacer handshake.

The block also presents the data word, taken from the one-rails. It raises a flag whenever any pair shows the forbidden both-high code.

The C-elements are modelled as clocked majority-with-feedback registers with a synchronous, active-high reset. The tree has `L = max(1, ceil(log2 W))` register levels. The tree leaves are padded to a power of two by reusing bit 0's present signal.

Top module: `dr_done_det`

## Requirements
- R1: Pair i is the bits (`rail1_i[i]`, `rail0_i[i]`). The code 00 is the spacer, 01 is logical 0, 10 is logical 1, and 11 is illegal.
- R2: Once all W pairs hold a data code, with every earlier arrival at least L+1 cycles before, `done_o` is low after L-1 rising edges and high after exactly L rising edges. This holds for any order of arrival.
- R3: While at least one pair is still the spacer during the data phase, `done_o` stays low, however long the wait.
- R4: Once all W pairs have returned to the spacer, `done_o` is still high after L-1 rising edges and low after exactly L rising edges.
- R5: While at least one pair still carries data during the return phase, `done_o` stays high.
- R6: `data_o[i]` equals `rail1_i[i]`. While `done_o` is high with legal codes, it is the decoded word: bit i is 1 for code 10 and 0 for code 01.
- R7: `err_o` is high, with no clock edge needed, whenever any pair shows 11, and low when no pair does.
- R8: A synchronous `rst` clears every C-element, so `done_o` is low one edge later, whatever the rails hold. After release, a fully valid bus raises `done_o` again after L edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the C-element hold registers |
| rst | input | 1 | Synchronous active-high reset |
| rail1_i | input | W | One-rail of each bit pair |
| rail0_i | input | W | Zero-rail of each bit pair |
| done_o | output | 1 | Completion: high when all bits valid, low when all spacer |
| data_o | output | W | Decoded word (one-rails) |
| err_o | output | 1 | Some pair shows the illegal 11 code |

## Verification
The hardest case to reach is a partly filled bus that has been held long enough for every subtree except one to settle. In that state only the single missing leaf stands between the tree and a change of `done_o`. The stimulus brings bits in one at a time in a shuffled order and waits more than L cycles after each one. This makes every partial pattern a settled state in which an early rise or fall would show. The same shuffled, spaced walk is used for the return to spacer, so the hold behaviour is tested against each last remaining bit.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic [1:0] {
        RAIL_SPACER = 2'b00,
        RAIL_ZERO   = 2'b01,
        RAIL_ONE    = 2'b10,
        RAIL_BAD    = 2'b11
    } rail_code_e;

    // Number of register levels in the completion tree (at least one).
    function automatic int tree_levels(input int width);
        int lv;
        lv = 0;
        while ((1 << lv) < width) lv++;
        if (lv < 1) lv = 1;
        return lv;
    endfunction

    // Majority of two inputs and the fed-back state.
    function automatic logic c_next(input logic a, input logic b, input logic q);
        return (a & b) | (q & (a | b));
    endfunction

endpackage

// File: rtl/c_elem.sv
module c_elem (
    input  logic clk,
    input  logic rst,
    input  logic a,
    input  logic b,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= dr_pkg::c_next(a, b, q);
    end
endmodule

// File: rtl/rail_front.sv
module rail_front #(
    parameter int W = 8
) (
    input  logic [W-1:0] rail1,
    input  logic [W-1:0] rail0,
    output logic [W-1:0] present,
    output logic [W-1:0] word,
    output logic         bad_any
);
    import dr_pkg::*;

    logic [W-1:0] bad;

    for (genvar i = 0; i < W; i++) begin : g_pair
        rail_code_e code;
        assign code       = rail_code_e'({rail1[i], rail0[i]});
        assign present[i] = (code != RAIL_SPACER);
        assign bad[i]     = (code == RAIL_BAD);
        assign word[i]    = (code == RAIL_ONE) || (code == RAIL_BAD);
    end

    assign bad_any = |bad;
endmodule

// File: rtl/c_tree.sv
module c_tree #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] leaf,
    output logic         root
);
    localparam int LVL = dr_pkg::tree_levels(W);
    localparam int N   = 1 << LVL;

    // Heap layout: node 1 is the root, nodes N..2N-1 are leaves.
    logic [2*N-1:1] nd;

    for (genvar k = 0; k < N; k++) begin : g_leaf
        if (k < W) begin : g_real
            assign nd[N+k] = leaf[k];
        end else begin : g_pad
            assign nd[N+k] = leaf[0];
        end
    end

    for (genvar i = 1; i < N; i++) begin : g_node
        c_elem u_c (
            .clk (clk),
            .rst (rst),
            .a   (nd[2*i]),
            .b   (nd[2*i+1]),
            .q   (nd[i])
        );
    end

    assign root = nd[1];
endmodule

// File: rtl/dr_done_det.sv
module dr_done_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rail1_i,
    input  logic [W-1:0] rail0_i,
    output logic         done_o,
    output logic [W-1:0] data_o,
    output logic         err_o
);
    logic [W-1:0] present;

    rail_front #(.W(W)) u_front (
        .rail1   (rail1_i),
        .rail0   (rail0_i),
        .present (present),
        .word    (data_o),
        .bad_any (err_o)
    );

    c_tree #(.W(W)) u_tree (
        .clk  (clk),
        .rst  (rst),
        .leaf (present),
        .root (done_o)
    );
endmodule

// File: rtl/dr_done_chk.sv
module dr_done_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] rail1_i,
    input logic [W-1:0] rail0_i,
    input logic         done_o,
    input logic [W-1:0] data_o,
    input logic         err_o
);
    localparam int LVL = dr_pkg::tree_levels(W);
    localparam int CW  = $clog2(LVL + 1) + 1;

    logic          all_in, all_out;
    logic [CW-1:0] in_run, out_run;

    assign all_in  = &(rail1_i | rail0_i);
    assign all_out = ~|(rail1_i | rail0_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_run  <= '0;
            out_run <= '0;
        end else begin
            in_run  <= !all_in  ? '0 : (in_run  >= CW'(LVL) ? in_run  : in_run  + 1'b1);
            out_run <= !all_out ? '0 : (out_run >= CW'(LVL) ? out_run : out_run + 1'b1);
        end
    end

    AST_RISE_AFTER_ALL_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (in_run >= CW'(LVL))); // R2
    AST_LOW_WHILE_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !all_in) |=> !done_o); // R3
    AST_FALL_AFTER_ALL_SPACER: assert property (@(posedge clk) disable iff (rst)
        $fell(done_o) |-> (out_run >= CW'(LVL))); // R4
    AST_HIGH_WHILE_DRAINING: assert property (@(posedge clk) disable iff (rst)
        (done_o && !all_out) |=> done_o); // R5
    AST_DATA_MATCHES_RAILS: assert property (@(posedge clk) disable iff (rst)
        (done_o && !err_o && all_in) |-> ((data_o ^ rail0_i) == {W{1'b1}})); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !done_o); // R8

    for (genvar g = 0; g < W; g++) begin : g_err
        AST_ERR_ON_BAD_PAIR: assert property (@(posedge clk) disable iff (rst)
            (rail1_i[g] && rail0_i[g]) |-> err_o); // R7
    end
endmodule

bind dr_done_det dr_done_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rail1_i (rail1_i),
    .rail0_i (rail0_i),
    .done_o  (done_o),
    .data_o  (data_o),
    .err_o   (err_o)
);

// File: tb/dr_done_det_tb_top.sv
`timescale 1ns/1ps
module dr_done_det_tb_top;
    localparam int W     = 8;
    localparam int LVL   = (W > 1) ? $clog2(W) : 1;
    localparam int NV    = 8;
    localparam int LIMIT = 100000;
    localparam logic [W-1:0] VEC [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h5A,
                                          8'h01, 8'h80, 8'h3C, 8'hC3};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] r1  = '0;
    logic [W-1:0] r0  = '0;
    logic         done;
    logic [W-1:0] data;
    logic         err;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int ord [W];

    always #2.5 clk = ~clk;

    dr_done_det #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .rail1_i(r1), .rail0_i(r0),
        .done_o(done), .data_o(data), .err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic shuffle();
        for (int i = 0; i < W; i++) ord[i] = i;
        for (int i = W - 1; i > 0; i--) begin
            int j, t;
            j = $urandom_range(i, 0);
            t = ord[i]; ord[i] = ord[j]; ord[j] = t;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=%0d expected<=%0d", cyc, LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset done", done, 0);
        chk("R7 reset err", err, 0);
        rst = 1'b0;
        @(negedge clk);

        // Table walk: shuffled, spaced arrival then shuffled, spaced return.
        for (int v = 0; v < NV; v++) begin
            shuffle();
            for (int k = 0; k < W; k++) begin
                r1[ord[k]] = VEC[v][ord[k]];
                r0[ord[k]] = !VEC[v][ord[k]];
                if (k < W - 1) begin
                    repeat (LVL + 1) @(negedge clk);
                    chk("R3 low while partial", done, 0);
                end else begin
                    repeat (LVL - 1) @(negedge clk);
                    chk("R2 not yet high", done, 0);
                    @(negedge clk);
                    chk("R2 high after L edges", done, 1);
                    chk("R6 R1 decoded word", data, VEC[v]);
                    chk("R7 no err on legal", err, 0);
                end
            end
            shuffle();
            for (int k = 0; k < W; k++) begin
                r1[ord[k]] = 1'b0;
                r0[ord[k]] = 1'b0;
                if (k < W - 1) begin
                    repeat (LVL + 1) @(negedge clk);
                    chk("R5 high while draining", done, 1);
                end else begin
                    repeat (LVL - 1) @(negedge clk);
                    chk("R4 not yet low", done, 1);
                    @(negedge clk);
                    chk("R4 low after L edges", done, 0);
                end
            end
        end

        // Illegal code detection.
        r1[3] = 1'b1; r0[3] = 1'b1;
        #1 chk("R7 err on 11", err, 1);
        r1[5] = 1'b1;
        #1 chk("R7 err with mixed", err, 1);
        @(negedge clk);
        r0[3] = 1'b0;
        #1 chk("R7 err cleared", err, 0);
        r1 = '0; r0 = '0;
        repeat (LVL + 1) @(negedge clk);
        chk("R3 stays low after err test", done, 0);

        // Reset with a full bus.
        r1 = 8'h3C; r0 = ~8'h3C;
        repeat (LVL) @(negedge clk);
        chk("R2 full bus at once", done, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 reset clears done", done, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (LVL - 1) @(negedge clk);
        chk("R8 not yet high after release", done, 0);
        @(negedge clk);
        chk("R8 high again after release", done, 1);
        r1 = '0; r0 = '0;
        repeat (LVL) @(negedge clk);
        chk("R4 all clear at once", done, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule